// File: doc/BRIEF.md
# One-Bit Stream DC Level Decimator

This block turns the single-bit output of an oversampled modulator into a signed DC estimate. Each sample is counted as +1 or -1 by an up/down accumulator. After a programmed number D of counted samples, the running total is copied into a result register and a one-cycle done pulse is raised. The accumulator is zeroed only on an explicit clear. An invert control flips the sense of the samples for a run, so two runs can be chained into a difference: clear and measure the first level, then measure the second level with invert set and without a clear. The result is then the first sum minus the second.

Each run is started by a start pulse and works in one of two arming modes. In preset mode, counting begins on the cycle after start. This suits a modulator whose integrator was loaded with the input value. In wait mode, the block remembers the bit present in the start cycle. It counts nothing until an enabled sample differs from that bit, and that differing sample is the first one counted. An enable input gates every sample.

Top module: `dc_decim_top`

## Requirements
- R1: With invert latched low, a counted sample of 1 adds +1 to the accumulator and a counted sample of 0 adds -1.
- R2: With invert high in the start cycle, the sense is reversed for the whole run: a 1 adds -1 and a 0 adds +1.
- R3: After the D-th counted sample of a run, `done` is high for exactly one cycle, and `result` then equals the accumulator total including that sample.
- R4: `dec_factor` is latched at start. A value of 1 (bypass) or 0 (treated as 1) ends the run after a single counted sample.
- R5: A `clear` while idle zeroes the accumulator. A run started without a clear continues from the previous total, so a clear, a normal run, then an inverted run yields first sum minus second sum.
- R6: In wait mode, enabled samples equal to the bit seen in the start cycle are not counted. The first enabled sample that differs is counted, and every enabled sample after it is counted.
- R7: In preset mode, counting starts with the sample of the cycle after start.
- R8: A sample in a cycle with `enable` low is neither counted nor able to arm a wait-mode run.
- R9: While `busy` is high, `start` and `clear` are ignored. The run keeps its settings, its count and its accumulator.
- R10: `valid` rises with `done` and stays high, with `result` unchanged, until the next accepted start drops it. `busy` is high from the cycle after an accepted start until `done`.
- R11: After reset, `result` is 0 and `done`, `valid` and `busy` are low.
- R12: The accumulator is DEC_W+2 bits wide and signed. A two-run total of up to ±2·(2^DEC_W−1) is exact and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | One-bit modulator stream |
| enable | input | 1 | Sample gate, one sample per cycle when high |
| dec_factor | input | DEC_W | Decimation factor D, latched at start (0 treated as 1) |
| start | input | 1 | Begin a run when idle |
| clear | input | 1 | Zero the accumulator when idle |
| invert | input | 1 | Reverse sample sense for the run, latched at start |
| preset_mode | input | 1 | 1: count from the next cycle; 0: wait for a transition |
| result | output | DEC_W+2 | Signed latched total |
| done | output | 1 | One-cycle pulse when result is latched |
| valid | output | 1 | Result holds a completed measurement |
| busy | output | 1 | A run is armed or counting |

## Verification
The bench builds the block with DEC_W = 4. D then tops out at 15 and the accumulator spans ±31. Because of that, the full-scale two-run difference of +30 and −30 is reachable in a few dozen cycles, and random decimation factors hit both bypass values, 0 and 1, often. The short runs also leave room for many random wait-mode runs with a gated enable, which exercises arming on the first differing sample.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } dcm_state_t;

  // Effective run length: a programmed zero behaves as one sample.
  function automatic int eff_len(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  // Signed contribution of one sample after the run's sense control.
  function automatic logic signed [1:0] bit_step(input logic b, input logic inv);
    return (b ^ inv) ? 2'sb01 : 2'sb11;
  endfunction

endpackage

// File: rtl/dcm_arm_ctrl.sv
module dcm_arm_ctrl #(
  parameter int DEC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             enable,
  input  logic             bit_in,
  input  logic             invert,
  input  logic             preset_mode,
  input  logic [DEC_W-1:0] dec_factor,
  output logic             start_ok,
  output logic             take,
  output logic             last,
  output logic             busy,
  output logic             inv_q
);
  import dcm_pkg::*;

  localparam int CW = DEC_W + 1;

  dcm_state_t       st;
  logic [DEC_W-1:0] d_q;
  logic [DEC_W-1:0] cnt;
  logic             ref_q;
  logic [CW-1:0]    d_eff;
  logic [CW-1:0]    cnt_inc;
  logic             armed_now;

  assign busy      = (st != ST_IDLE);
  assign start_ok  = start && !busy;
  assign armed_now = (st == ST_RUN) || ((st == ST_ARM) && (bit_in != ref_q));
  assign take      = enable && armed_now;
  assign d_eff     = CW'(eff_len(int'(d_q)));
  assign cnt_inc   = {1'b0, cnt} + CW'(1);
  assign last      = take && (cnt_inc == d_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      d_q   <= '0;
      cnt   <= '0;
      ref_q <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start_ok) begin
            st    <= preset_mode ? ST_RUN : ST_ARM;
            d_q   <= dec_factor;
            cnt   <= '0;
            ref_q <= bit_in;
            inv_q <= invert;
          end
        end
        ST_ARM, ST_RUN: begin
          if (take) begin
            if (last) begin
              st  <= ST_IDLE;
              cnt <= '0;
            end else begin
              st  <= ST_RUN;
              cnt <= cnt_inc[DEC_W-1:0];
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: an in-flight run cannot be cut short by anything but its last sample
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy);

  // R7: preset mode goes straight to counting
  p_preset_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok && preset_mode |=> (st == ST_RUN));

  // R6: a sample equal to the start-cycle bit leaves the run waiting
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARM) && (bit_in == ref_q) |=> (st == ST_ARM));

  // R8: a gated sample never advances the count
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) && !enable |=> $stable(cnt) && (st == ST_RUN));

endmodule

// File: rtl/dcm_updown_acc.sv
module dcm_updown_acc #(
  parameter int ACC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    take,
  input  logic signed [1:0]       step,
  output logic signed [ACC_W-1:0] sum_next
);
  logic signed [ACC_W-1:0] acc;

  assign sum_next = acc + {{(ACC_W-2){step[1]}}, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (clr)  acc <= '0;
    else if (take) acc <= sum_next;
  end

  // R12: an up step always increases the signed total, a down step decreases it
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    take && !clr && (step == 2'sb01) |=> (acc > $past(acc)));
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    take && !clr && (step == 2'sb11) |=> (acc < $past(acc)));

  // R8: with no counted sample and no clear the total holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take && !clr |=> $stable(acc));

  // R5: clear leaves a zero total
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));

endmodule

// File: rtl/dc_decim_top.sv
module dc_decim_top #(
  parameter int DEC_W = 6,
  localparam int ACC_W = DEC_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             enable,
  input  logic [DEC_W-1:0] dec_factor,
  input  logic             start,
  input  logic             clear,
  input  logic             invert,
  input  logic             preset_mode,
  output logic [ACC_W-1:0] result,
  output logic             done,
  output logic             valid,
  output logic             busy
);
  import dcm_pkg::*;

  logic                    start_ok;
  logic                    take;
  logic                    last;
  logic                    inv_q;
  logic                    clr_ok;
  logic signed [1:0]       step;
  logic signed [ACC_W-1:0] sum_next;

  assign clr_ok = clear && !busy;
  assign step   = bit_step(bit_in, inv_q);

  dcm_arm_ctrl #(.DEC_W(DEC_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .enable     (enable),
    .bit_in     (bit_in),
    .invert     (invert),
    .preset_mode(preset_mode),
    .dec_factor (dec_factor),
    .start_ok   (start_ok),
    .take       (take),
    .last       (last),
    .busy       (busy),
    .inv_q      (inv_q)
  );

  dcm_updown_acc #(.ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_ok),
    .take    (take),
    .step    (step),
    .sum_next(sum_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
      valid  <= 1'b0;
    end else begin
      done <= last;
      if (last) begin
        result <= sum_next;
        valid  <= 1'b1;
      end else if (start_ok) begin
        valid <= 1'b0;
      end
    end
  end

  // R3: done is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: a valid result stays put until a start is accepted
  p_valid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !start_ok && !last |=> valid && $stable(result));

  // R10: done always comes with valid and ends the busy window
  p_done_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> valid && !busy);

endmodule

// File: tb/tb_dc_decim_top.sv
module tb_dc_decim_top;
  localparam int DW = 4;
  localparam int AW = DW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_in = 1'b0;
  logic          enable = 1'b0;
  logic [DW-1:0] dec_factor = '0;
  logic          start = 1'b0;
  logic          clear = 1'b0;
  logic          invert = 1'b0;
  logic          preset_mode = 1'b0;
  logic [AW-1:0] result;
  logic          done;
  logic          valid;
  logic          busy;

  int checks = 0;
  int errors = 0;
  int acc_m  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dc_decim_top #(.DEC_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .enable(enable),
    .dec_factor(dec_factor), .start(start), .clear(clear), .invert(invert),
    .preset_mode(preset_mode), .result(result), .done(done), .valid(valid),
    .busy(busy)
  );

  function automatic int len_of(input int d);
    if (d == 0) return 1;
    return d;
  endfunction

  function automatic int weight(input bit b, input bit inv);
    if (b != inv) return 1;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pat: 0 random, 1 ones, 2 zeros, 3 alternating
  task automatic run_meas(input int d, input bit pre, input bit inv, input bit clr,
                          input int pat, input int hold, input int en_pct,
                          input bit poke, input string req);
    int  cnt = 0;
    int  n = 0;
    int  deff = len_of(d);
    int  spur = 0;
    bit  armed = pre;
    bit  ref_b;
    bit  b;
    bit  en;
    logic [AW-1:0] e;
    @(negedge clk);
    if (pat == 1) ref_b = 1'b0;
    else if (pat == 2) ref_b = 1'b1;
    else ref_b = 1'($urandom_range(0, 1));
    start = 1'b1; clear = clr; invert = inv; preset_mode = pre;
    dec_factor = DW'(d); bit_in = ref_b; enable = 1'b1;
    if (clr) acc_m = 0;
    @(negedge clk);
    start = 1'b0; clear = 1'b0;
    check(busy == 1'b1 && valid == 1'b0, {req, " busy/valid after start R10"}, busy, 1);
    while (cnt < deff && n < 3000) begin
      if (n < hold) b = ref_b;
      else if (pat == 1) b = 1'b1;
      else if (pat == 2) b = 1'b0;
      else if (pat == 3) b = 1'(n & 1);
      else b = 1'($urandom_range(0, 1));
      en = ($urandom_range(0, 99) < en_pct) || (n < hold);
      bit_in = b; enable = en;
      invert = ~inv; preset_mode = ~pre; dec_factor = DW'(d + 3);
      if (poke && n == 1) begin start = 1'b1; clear = 1'b1; end
      if (!armed && en && b != ref_b) armed = 1'b1;
      if (armed && en) begin acc_m += weight(b, inv); cnt++; end
      @(negedge clk);
      start = 1'b0; clear = 1'b0;
      n++;
      if (cnt < deff && done) spur++;
    end
    enable = 1'b0;
    e = AW'(acc_m);
    check(spur == 0, {req, " no early done R3"}, spur, 0);
    check(done == 1'b1 && valid == 1'b1, {req, " done/valid R3"}, done, 1);
    check(result == e, {req, " result"}, $signed(result), acc_m);
  endtask

  initial begin
    int d;
    logic [AW-1:0] held;
    void'($urandom(32'h5eed_1234));
    #20;
    check(result == '0 && !done && !valid && !busy, "R11 reset state", result, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !valid, "R11 idle after release", busy, 0);

    // R1 counting sense, preset, D=5 all ones then all zeros
    run_meas(5, 1, 0, 1, 1, 0, 100, 0, "R1 ones");
    run_meas(5, 1, 0, 1, 2, 0, 100, 0, "R1 zeros R7");
    // R2 inverted sense
    run_meas(6, 1, 1, 1, 1, 0, 100, 0, "R2 inverted ones");
    // R4 bypass and zero factor
    run_meas(1, 1, 0, 1, 1, 0, 100, 0, "R4 D=1");
    run_meas(0, 1, 0, 1, 2, 0, 100, 0, "R4 D=0");
    // R6 wait mode: held bits ignored, first differing counted
    run_meas(3, 0, 0, 1, 2, 4, 100, 0, "R6 wait after hold");
    run_meas(4, 0, 0, 1, 3, 2, 100, 0, "R6 wait alternating");
    // R8 gated enable
    run_meas(9, 1, 0, 1, 0, 0, 40, 0, "R8 gated");
    run_meas(7, 0, 1, 1, 0, 0, 50, 0, "R8 gated wait");
    // R9 start and clear ignored while busy
    run_meas(6, 1, 0, 1, 1, 0, 100, 1, "R9 poke preset");
    run_meas(8, 0, 0, 0, 0, 1, 100, 1, "R9 poke wait");
    // R5 differential chain
    run_meas(7, 1, 0, 1, 0, 0, 100, 0, "R5 diff first");
    run_meas(7, 1, 1, 0, 0, 0, 100, 0, "R5 diff second");
    // R12 full-scale differential both signs
    run_meas(15, 1, 0, 1, 1, 0, 100, 0, "R12 pos first");
    run_meas(15, 1, 1, 0, 2, 0, 100, 0, "R12 pos second");
    run_meas(15, 1, 0, 1, 2, 0, 100, 0, "R12 neg first");
    run_meas(15, 1, 1, 0, 1, 0, 100, 0, "R12 neg second");

    // R10 hold after done
    held = result;
    for (int i = 0; i < 5; i++) begin
      bit_in = 1'($urandom_range(0, 1)); enable = 1'b1;
      @(negedge clk);
    end
    enable = 1'b0;
    check(valid == 1'b1 && result == held && !done && !busy, "R10 hold", $signed(result), $signed(held));

    // random mix
    for (int k = 0; k < 60; k++) begin
      d = $urandom_range(0, 15);
      run_meas(d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 3) != 0), 0, $urandom_range(0, 3),
               $urandom_range(30, 100), 1'($urandom_range(0, 1)), "R3 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule